// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Interface Sequencer

This block is the digital front of a delta-sigma converter. It steps through a repeating cycle of calibration, conversion and sleep. When a result is ready it waits for the host to read it as a 24-bit serial frame. While a conversion runs, the same data line acts as a busy flag. The line drives only while chip select is low and floats otherwise, so other devices can share the bus.

The host picks the direction of the serial clock at each falling edge of chip select. If the clock line is high at that edge, the block generates the clock itself by dividing the conversion clock by eight. If the line is low, the host supplies the clock. Output bits change on clock falling edges, so the host samples on rising edges. The frame opens with the busy flag (low), then the sign bit, then the result from MSB down to LSB. The 24th falling edge starts a new cycle. If chip select rises at any point during the frame, the transfer ends early and a new cycle starts at once.

The calibration length is a parameter counted in conversion-clock cycles. The conversion phase runs until a done strobe arrives from the filter. Chip select and the external clock are synchronized into the conversion-clock domain. The conversion clock must run at least four times faster than the external serial clock.

Top module: `dsadc_serial_ctrl`

## Requirements
- R1: During and right after reset, sdo_oe is 0, internal clock mode is selected (sck_oe = 1, sck_out = 0), start_conv is 0 and a calibration phase is running.
- R2: Each cycle begins with CAL_CYC conversion-clock cycles of calibration. After reset is released, start_conv is high for one cycle, sampled after exactly CAL_CYC rising clock edges. The conversion phase then lasts until conv_done, which latches res_word. A conv_done outside the conversion phase has no effect.
- R3: sdo_oe is 1 exactly when the synchronized chip select is low. During calibration and conversion sdo = 1 (busy). In sleep sdo = 0.
- R4: After the conversion ends, the block stays in sleep until the first serial-clock rising edge seen with chip select low. Clock edges while chip select is high leave the held frame untouched.
- R5: The frame is 24 bits and is sampled on serial-clock rising edges. Bit 1 is the busy flag (0), bit 2 is res_word[22] (sign), and bits 3 to 24 are res_word[21] down to res_word[0]. Each bit after the first appears after a falling edge.
- R6: On the 24th serial-clock falling edge a new cycle begins and sdo returns to 1.
- R7: A rise of chip select during the frame aborts it and starts a new cycle at once. The next full frame carries the next result unchanged. A chip-select rise in any other state has no effect.
- R8: At each chip-select fall the serial clock line is sampled. High selects internal mode: sck_oe = 1 and sck_out has a period of 8 conversion-clock cycles. Low selects external mode: sck_oe = 0 and sck_in clocks the frame.
- R9: In internal mode sck_out toggles only while chip select is low and the block is in sleep or frame output. Otherwise it stays at 0.
- R10: A chip-select rise that falls in the same cycle as the 24th falling edge starts exactly one new cycle, giving one start_conv pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck_in | input | 1 | Serial clock from the host (external mode), level sampled for mode choice |
| conv_done | input | 1 | One-cycle strobe: the filter result is ready |
| res_word | input | FRAME_W-1 | Sign bit followed by the result, MSB first |
| sdo | output | 1 | Serial data / busy flag |
| sdo_oe | output | 1 | Output enable for sdo |
| sck_out | output | 1 | Generated serial clock (internal mode) |
| sck_oe | output | 1 | Output enable for sck_out |
| start_conv | output | 1 | One-cycle pulse at the start of the conversion phase |

## Verification
The end of a frame and an abort can land in the same cycle. This happens when the host raises chip select together with the 24th falling clock edge. The bench drives both transitions at the same instant, so both reach the synchronizers in the same cycle. It then counts start_conv pulses over three calibration lengths and requires exactly one. The next frame in internal mode must then carry the next result bit for bit.

// File: rtl/dsadc_serial_ctrl.sv
module dsadc_serial_ctrl #(
  parameter int FRAME_W = 24,
  parameter int CAL_CYC = 500000,
  parameter int SCK_DIV = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sck_in,
  input  logic               conv_done,
  input  logic [FRAME_W-2:0] res_word,
  output logic               sdo,
  output logic               sdo_oe,
  output logic               sck_out,
  output logic               sck_oe,
  output logic               start_conv
);
  localparam int DIV_W = $clog2(SCK_DIV);
  localparam int CNT_W = $clog2(CAL_CYC + 1);
  localparam int BIT_W = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {ST_CAL, ST_CONV, ST_SLEEP, ST_OUT} st_t;

  st_t                st;
  logic [2:0]         cs_q, sck_q;
  logic               mode_ext;
  logic [DIV_W-1:0]   div;
  logic [CNT_W-1:0]   cal_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic [FRAME_W-2:0] hold;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q  <= '1;
      sck_q <= '1;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck_in};
    end

  wire cs_lo   = ~cs_q[1];
  wire cs_fall = cs_q[2] & ~cs_q[1];
  wire cs_rise = ~cs_q[2] & cs_q[1];
  wire x_rise  = sck_q[1] & ~sck_q[2];
  wire x_fall  = ~sck_q[1] & sck_q[2];

  wire run     = ~mode_ext & cs_lo & (st == ST_SLEEP || st == ST_OUT);
  wire rise_ev = mode_ext ? x_rise : run & (div == DIV_W'(SCK_DIV/2 - 1));
  wire fall_ev = mode_ext ? x_fall : run & (div == DIV_W'(SCK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_ext <= 1'b0;
    else if (cs_fall) mode_ext <= ~sck_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div <= '0;
    else if (run) div <= div + 1'b1;
    else div <= '0;

  assign sck_out = div[DIV_W-1];
  assign sck_oe  = ~mode_ext;
  assign sdo_oe  = cs_lo;
  assign sdo     = (st == ST_OUT) ? shreg[FRAME_W-1] : (st == ST_CAL || st == ST_CONV);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= ST_CAL;
      cal_cnt    <= '0;
      bit_cnt    <= '0;
      hold       <= '0;
      shreg      <= '0;
      start_conv <= 1'b0;
    end else begin
      start_conv <= 1'b0;
      case (st)
        ST_CAL:
          if (cal_cnt == CNT_W'(CAL_CYC - 1)) begin
            st         <= ST_CONV;
            start_conv <= 1'b1;
          end else cal_cnt <= cal_cnt + 1'b1;
        ST_CONV:
          if (conv_done) begin
            st   <= ST_SLEEP;
            hold <= res_word;
          end
        ST_SLEEP:
          if (rise_ev && cs_lo) begin
            st      <= ST_OUT;
            shreg   <= {1'b0, hold};
            bit_cnt <= '0;
          end
        ST_OUT:
          if (cs_rise) begin
            st      <= ST_CAL;
            cal_cnt <= '0;
          end else if (fall_ev) begin
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
            if (bit_cnt == BIT_W'(FRAME_W - 1)) begin
              st      <= ST_CAL;
              cal_cnt <= '0;
            end else bit_cnt <= bit_cnt + 1'b1;
          end
        default: st <= ST_CAL;
      endcase
    end

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |=> !start_conv);
  p_done_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CONV && conv_done) |=> (st == ST_SLEEP));
  p_sleep_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLEEP && !cs_n && $past(!cs_n) && $past(!cs_n, 2)) |-> (sdo_oe && !sdo));
  p_bitcnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OUT) |-> (bit_cnt < BIT_W'(FRAME_W)));
  p_frame_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OUT && fall_ev && bit_cnt == BIT_W'(FRAME_W - 1)) |=> (st == ST_CAL && sdo));
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OUT && cs_rise) |=> (st == ST_CAL && sdo));
  p_ext_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ext |-> !sck_out);
  p_idle_sck_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CAL || st == ST_CONV) |-> !sck_out);
endmodule

// File: tb/tb_dsadc_serial_ctrl.sv
module tb_dsadc_serial_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CAL = 40;

  logic clk = 0, rst_n = 0, cs_n = 1, sck_in = 0, conv_done = 0;
  logic [22:0] res_word = '0;
  logic sdo, sdo_oe, sck_out, sck_oe, start_conv;
  int checks = 0, fails = 0;

  localparam logic [22:0] VEC [4] = '{23'h000001, 23'h7FFFFF, 23'h2AAAAA, 23'h4C3E19};

  dsadc_serial_ctrl #(.FRAME_W(24), .CAL_CYC(CAL), .SCK_DIV(8)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_in(sck_in), .conv_done(conv_done),
    .res_word(res_word), .sdo(sdo), .sdo_oe(sdo_oe), .sck_out(sck_out),
    .sck_oe(sck_oe), .start_conv(start_conv));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_start(input string req);
    int k = 0;
    while (!start_conv && k < 20 * CAL) begin @(negedge clk); k++; end
    chk(req, start_conv, 1);
    @(negedge clk);
  endtask

  task automatic finish_conv(input logic [22:0] w);
    clks(3);
    res_word = w; conv_done = 1;
    @(negedge clk);
    conv_done = 0;
    clks(4);
  endtask

  task automatic shift_ext(input int n, output logic [23:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      got[23-i] = sdo;
      sck_in = 1; clks(6);
      sck_in = 0; clks(6);
    end
  endtask

  logic [23:0] got;
  int n, pulses;
  realtime t1, t2;

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clks(3);
    chk("R1 sdo_oe", sdo_oe, 0);
    chk("R1 sck_oe", sck_oe, 1);
    chk("R1 sck_out", sck_out, 0);
    chk("R1 start", start_conv, 0);
    rst_n = 1;
    n = 0;
    while (!start_conv && n < 10 * CAL) begin @(negedge clk); n++; end
    chk("R2 cal length", n, CAL);
    @(negedge clk);
    chk("R2 pulse width", start_conv, 0);
    cs_n = 0; clks(4);
    chk("R3 oe low cs", sdo_oe, 1);
    chk("R3 busy", sdo, 1);

    for (int i = 0; i < 4; i++) begin
      if (i > 0) wait_start("R2 start");
      finish_conv(VEC[i]);
      chk("R3 sleep flag", sdo, 0);
      shift_ext(24, got);
      chk("R5 frame", got, {1'b0, VEC[i]});
      clks(2);
      chk("R6 new cycle", sdo, 1);
    end

    conv_done = 1; res_word = 23'h111111; @(negedge clk); conv_done = 0;
    wait_start("R2 start");
    clks(3);
    chk("R2 done in cal ignored", sdo, 1);
    finish_conv(23'h0F0F0F);
    shift_ext(24, got);
    chk("R2 frame", got, {1'b0, 23'h0F0F0F});

    wait_start("R2 start");
    cs_n = 1; clks(4);
    chk("R3 hi-z", sdo_oe, 0);
    finish_conv(23'h35A5C3);
    for (int i = 0; i < 3; i++) begin sck_in = 1; clks(6); sck_in = 0; clks(6); end
    chk("R4 hi-z in sleep", sdo_oe, 0);
    cs_n = 0; clks(4);
    chk("R4 still sleep", sdo, 0);
    shift_ext(24, got);
    chk("R4 R7 frame intact", got, {1'b0, 23'h35A5C3});

    wait_start("R2 start");
    finish_conv(23'h123456);
    shift_ext(5, got);
    cs_n = 1; clks(5);
    chk("R7 abort hi-z", sdo_oe, 0);
    cs_n = 0; clks(5);
    chk("R7 abort restarts", sdo, 1);
    wait_start("R7 start after abort");
    finish_conv(23'h654321);
    shift_ext(24, got);
    chk("R7 next frame", got, {1'b0, 23'h654321});

    wait_start("R2 start");
    finish_conv(23'h0000FF);
    shift_ext(23, got);
    sck_in = 1; clks(6);
    sck_in = 0; cs_n = 1;
    pulses = 0;
    for (int i = 0; i < 3 * CAL; i++) begin @(negedge clk); if (start_conv) pulses++; end
    chk("R10 single restart", pulses, 1);
    chk("R10 hi-z", sdo_oe, 0);

    sck_in = 1; clks(4);
    cs_n = 0; clks(5);
    chk("R8 internal oe", sck_oe, 1);
    chk("R9 idle in conv", sck_out, 0);
    chk("R3 busy", sdo, 1);
    res_word = 23'h5E5E5E; conv_done = 1; @(negedge clk); conv_done = 0;
    got = '0;
    for (int i = 0; i < 24; i++) begin
      @(posedge sck_out); #1;
      if (i == 0) t1 = $realtime;
      if (i == 1) t2 = $realtime;
      got[23-i] = sdo;
    end
    chk("R5 R8 internal frame", got, {1'b0, 23'h5E5E5E});
    chk("R8 period", int'(t2 - t1), 8 * CLK_PERIOD);
    clks(8);
    chk("R6 new cycle", sdo, 1);
    chk("R9 sck idle", sck_out, 0);

    cs_n = 1; sck_in = 0; clks(5);
    cs_n = 0; clks(5);
    chk("R8 external oe", sck_oe, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule